// File: doc/BRIEF.md
# Matrix Keypad Scanner with Dual One-Hot Key Vector

This block scans a 4x4 key matrix. It raises one column line at a time and reads four row lines. The rows are pulled low, so a row with no pressed key reads 0. Each column is held for a set dwell time. At the end of the dwell the synchronized row lines are sampled. If the sample is zero, the scanner moves on to the next column. If a key is seen, the scanner stays on that column until the rows clear.

A key is reported as an 8-bit vector with two one-hot nibbles. The upper nibble gives the column weight and the lower nibble gives the row weight. The same key is also given as the ASCII character of its hexadecimal label.

A simple debounce filter checks each press. The press is accepted only after the same vector has been sampled on a set number of consecutive samples. A one-cycle strobe then marks the new key. A held key produces no second strobe until the matrix has read empty on a full pass. A sample with more than one row bit set is discarded.

Top module: `kps_keypad_scan`

## Requirements
- R1: While reset is high, and on the first cycle after it, the block shows `col_code`=0, `col_onehot`=4'b0001, `key_valid`=0, `key_vec`=8'h00 and `key_ascii`=8'h00.
- R2: With all rows reading zero, `col_code` steps 0,1,2,3,0,... and holds each value for exactly DWELL cycles. `col_onehot` has only bit n high while `col_code` is n.
- R3: When the rows sampled for a column are nonzero, the scanner stays on that column. It keeps sampling that column until a sample reads zero.
- R4: Row input bit r stands for row r+1, with weight 1, 2, 4 or 8. These weights appear unchanged in `key_vec[3:0]`.
- R5: `key_vec[7:4]` is one-hot. Bit 4+c is set for column c+1, so column 2 row 3 gives 8'h24 and column 4 row 4 gives 8'h88.
- R6: The key index is 4*(row-1)+(column-1). `key_ascii` is 8'h30 plus the index for indexes 0 to 9, and 8'h41 plus (index-10) for indexes 10 to 15.
- R7: A press is accepted only after STABLE_SCANS consecutive samples with the same single-bit vector. A zero sample restarts the count, so a press shorter than that gives no strobe and leaves `key_vec` unchanged.
- R8: `key_valid` is high for exactly one cycle per accepted press. No further strobe occurs until four consecutive zero samples (one empty pass) have been seen. After that, a new press of the same key is reported again.
- R9: A sample with more than one row bit set is ignored. It gives no strobe and does not change `key_vec` or `key_ascii`.
- R10: `key_vec` and `key_ascii` keep the last accepted key after that key is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_in | input | 4 | Row lines from the matrix, active high (bit 0 is row 1) |
| col_code | output | 2 | Binary code of the driven column |
| col_onehot | output | 4 | One-hot active-high column drive |
| key_vec | output | 8 | Last accepted key: column weight in the high nibble, row weight in the low nibble |
| key_ascii | output | 8 | ASCII character of the last accepted key's hexadecimal label |
| key_valid | output | 1 | One-cycle strobe when a new key is accepted |

## Verification
A fault in the column counter or the dwell counter appears on `col_code` within one pass of 4*DWELL cycles, either as a skipped step or as a run of the wrong length. A fault in the park logic shows up as the column changing while a key is held. The bench models the key matrix from `col_onehot`, so a wrong column weight or a wrong row weight appears in `key_vec` or `key_ascii` at the first strobe of the sweep over all 16 keys. Errors in the filter's count or in its re-arm logic appear as a missing strobe or an extra strobe during a long hold, a short tap or a multi-row press. Each of these shows up within a few scan passes.

// File: rtl/kps_pkg.sv
package kps_pkg;
  localparam int KP_COLS = 4;
  localparam int KP_ROWS = 4;

  typedef logic [1:0] col_idx_t;
  typedef logic [3:0] nib_t;

  typedef struct packed {
    nib_t col_w;
    nib_t row_w;
  } kvec_t;

  function automatic col_idx_t oh_to_idx(input nib_t oh);
    col_idx_t idx;
    idx = 2'd0;
    for (int i = 0; i < KP_ROWS; i++) begin
      if (oh[i]) idx = col_idx_t'(i);
    end
    return idx;
  endfunction

  function automatic logic [7:0] label_ascii(input col_idx_t c, input col_idx_t r);
    logic [3:0] idx;
    idx = {r, c};
    if (idx < 4'd10) return 8'h30 + {4'd0, idx};
    else             return 8'h37 + {4'd0, idx};
  endfunction
endpackage

// File: rtl/kps_row_sync.sv
module kps_row_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] pipe [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
          pipe[0] <= d;
          for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign q = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/kps_col_scan.sv
module kps_col_scan
  import kps_pkg::*;
#(
  parameter int DWELL = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  nib_t     rows_s,
  output col_idx_t col_code,
  output nib_t     col_oh,
  output logic     samp_stb,
  output nib_t     samp_rows,
  output col_idx_t samp_col
);
  localparam int DW = (DWELL > 1) ? $clog2(DWELL) : 1;

  logic [DW-1:0] dcnt;
  col_idx_t      col_q;
  nib_t          oh_q;
  logic          last;

  assign last = (dcnt == DW'(DWELL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt      <= '0;
      col_q     <= '0;
      oh_q      <= 4'b0001;
      samp_stb  <= 1'b0;
      samp_rows <= '0;
      samp_col  <= '0;
    end else begin
      samp_stb <= 1'b0;
      if (last) begin
        dcnt      <= '0;
        samp_stb  <= 1'b1;
        samp_rows <= rows_s;
        samp_col  <= col_q;
        if (rows_s == '0) begin
          col_q <= col_q + 2'd1;
          oh_q  <= {oh_q[KP_COLS-2:0], oh_q[KP_COLS-1]};
        end
      end else begin
        dcnt <= dcnt + DW'(1);
      end
    end
  end

  assign col_code = col_q;
  assign col_oh   = oh_q;

  AST_COL_PARK: assert property (@(posedge clk) disable iff (rst)
    (last && rows_s != '0) |=> $stable(col_q)); // R3
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (last && rows_s == '0) |=> (col_q == $past(col_q) + 2'd1)); // R2
  AST_COL_DECODE: assert property (@(posedge clk) disable iff (rst)
    (oh_q == (4'b0001 << col_q))); // R2
endmodule

// File: rtl/kps_debounce.sv
module kps_debounce
  import kps_pkg::*;
#(
  parameter int STABLE_SCANS = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        samp_stb,
  input  nib_t        samp_rows,
  input  col_idx_t    samp_col,
  output logic        key_valid,
  output kvec_t       key_vec,
  output logic [7:0]  key_ascii
);
  localparam int CW = $clog2(STABLE_SCANS + 1);
  localparam int ZW = $clog2(KP_COLS + 1);

  kvec_t         cand;
  kvec_t         vec_now;
  logic [CW-1:0] cnt, ncnt;
  logic [ZW-1:0] zrun;
  logic          armed;
  logic          single;
  logic          same;

  assign single  = (samp_rows != '0) && ((samp_rows & (samp_rows - 4'd1)) == '0);
  assign vec_now = '{col_w: (4'b0001 << samp_col), row_w: samp_rows};
  assign same    = (vec_now == cand) && (cnt != '0);

  always_comb begin
    if (!same)                          ncnt = CW'(1);
    else if (cnt == CW'(STABLE_SCANS))  ncnt = cnt;
    else                                ncnt = cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand      <= '0;
      cnt       <= '0;
      zrun      <= '0;
      armed     <= 1'b1;
      key_valid <= 1'b0;
      key_vec   <= '0;
      key_ascii <= '0;
    end else begin
      key_valid <= 1'b0;
      if (samp_stb) begin
        if (samp_rows == '0) begin
          cnt <= '0;
          if (zrun != ZW'(KP_COLS)) zrun <= zrun + ZW'(1);
          if (zrun >= ZW'(KP_COLS - 1)) armed <= 1'b1;
        end else begin
          zrun <= '0;
          if (single) begin
            cand <= vec_now;
            cnt  <= ncnt;
            if (armed && ncnt == CW'(STABLE_SCANS)) begin
              armed     <= 1'b0;
              key_valid <= 1'b1;
              key_vec   <= vec_now;
              key_ascii <= label_ascii(samp_col, oh_to_idx(samp_rows));
            end
          end
        end
      end
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid); // R8
  AST_PULSE_FROM_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> $past(samp_stb)); // R7
  AST_NO_MULTI_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (samp_stb && !single) |=> $stable(key_vec)); // R9
endmodule

// File: rtl/kps_keypad_scan.sv
module kps_keypad_scan
  import kps_pkg::*;
#(
  parameter int DWELL        = 4,
  parameter int STABLE_SCANS = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] row_in,
  output logic [1:0] col_code,
  output logic [3:0] col_onehot,
  output logic [7:0] key_vec,
  output logic [7:0] key_ascii,
  output logic       key_valid
);
  nib_t     rows_s;
  logic     samp_stb;
  nib_t     samp_rows;
  col_idx_t samp_col;
  kvec_t    vec_q;

  kps_row_sync #(.W(KP_ROWS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(row_in), .q(rows_s)
  );

  kps_col_scan #(.DWELL(DWELL)) u_scan (
    .clk(clk), .rst(rst), .rows_s(rows_s),
    .col_code(col_code), .col_oh(col_onehot),
    .samp_stb(samp_stb), .samp_rows(samp_rows), .samp_col(samp_col)
  );

  kps_debounce #(.STABLE_SCANS(STABLE_SCANS)) u_deb (
    .clk(clk), .rst(rst),
    .samp_stb(samp_stb), .samp_rows(samp_rows), .samp_col(samp_col),
    .key_valid(key_valid), .key_vec(vec_q), .key_ascii(key_ascii)
  );

  assign key_vec = vec_q;

  AST_VEC_FORMAT: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> ($onehot(key_vec[7:4]) && $onehot(key_vec[3:0]))); // R5
  AST_ASCII_RANGE: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> ((key_ascii >= 8'h30 && key_ascii <= 8'h39) ||
                   (key_ascii >= 8'h41 && key_ascii <= 8'h46))); // R6
endmodule

// File: tb/kps_keypad_scan_tb.sv
module kps_keypad_scan_tb;
  localparam int DWELL = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_in;
  logic [1:0] col_code;
  logic [3:0] col_onehot;
  logic [7:0] key_vec, key_ascii;
  logic       key_valid;
  logic [15:0] pressed = '0;

  int checks = 0, errors = 0, pulses = 0;
  logic [7:0] cap_vec = '0, cap_asc = '0;
  bit done = 0;

  always #4 clk = ~clk;

  kps_keypad_scan #(.DWELL(DWELL), .STABLE_SCANS(3), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .row_in(row_in), .col_code(col_code),
    .col_onehot(col_onehot), .key_vec(key_vec), .key_ascii(key_ascii),
    .key_valid(key_valid)
  );

  // matrix model: key index = 4*row + col
  always_comb begin
    for (int r = 0; r < 4; r++) row_in[r] = |(pressed[4*r +: 4] & col_onehot);
  end

  always @(negedge clk) begin
    if (!rst && key_valid) begin
      pulses  <= pulses + 1;
      cap_vec <= key_vec;
      cap_asc <= key_ascii;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev, run, seen;
    logic [7:0] ev, ea, held;
    waitn(4);
    chk(col_code == 2'd0 && col_onehot == 4'b0001, "R1 col", {col_code, col_onehot}, 6'h01);
    chk(key_valid == 0 && key_vec == 0 && key_ascii == 0, "R1 key", {key_valid, key_vec, key_ascii}, 0);
    rst = 1'b0;
    waitn(1);
    chk(col_code == 2'd0 && key_valid == 0 && key_vec == 0, "R1 after", {col_code, key_vec}, 0);

    // R2 column rotation and dwell length
    prev = col_code; run = 0; seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      run++;
      if (col_code != prev) begin
        if (seen > 0) chk(run == DWELL, "R2 dwell", run, DWELL);
        chk(col_code == 2'(prev + 1), "R2 step", col_code, 2'(prev + 1));
        chk(col_onehot == (4'b1 << col_code), "R2 onehot", col_onehot, 4'b1 << col_code);
        seen++; run = 0; prev = col_code;
      end
    end

    // sweep all 16 keys: R4 R5 R6 R8
    for (int k = 0; k < 16; k++) begin
      int c, r;
      c = k % 4; r = k / 4;
      pulses = 0;
      pressed = 16'(1) << k;
      waitn(150);
      ev = 8'((1 << c) << 4) | 8'(1 << r);
      ea = (k < 10) ? 8'(8'h30 + k) : 8'(8'h41 + k - 10);
      chk(pulses == 1, "R8 single strobe", pulses, 1);
      chk(cap_vec == ev, "R4/R5 vector", cap_vec, ev);
      chk(cap_asc == ea, "R6 ascii", cap_asc, ea);
      pressed = '0;
      waitn(60);
    end

    // R3 park on column 3 (code 2), row 2
    pressed = 16'(1) << (4*1 + 2);
    waitn(100);
    chk(col_code == 2'd2, "R3 park code", col_code, 2);
    waitn(13);
    chk(col_code == 2'd2 && col_onehot == 4'b0100, "R3 park held", col_onehot, 4'b0100);
    pressed = '0;
    waitn(60);
    chk(key_vec == 8'h42 && key_ascii == 8'h36, "R10 hold after release", key_vec, 8'h42);

    // R8 long hold then re-press
    pulses = 0;
    pressed = 16'(1) << 5;
    waitn(600);
    chk(pulses == 1, "R8 long hold", pulses, 1);
    pressed = '0;
    waitn(60);
    pulses = 0;
    pressed = 16'(1) << 5;
    waitn(150);
    chk(pulses == 1, "R8 re-press", pulses, 1);
    pressed = '0;
    waitn(60);
    held = key_vec;

    // R7 short tap
    pulses = 0;
    pressed = 16'(1);
    waitn(3);
    pressed = '0;
    waitn(100);
    chk(pulses == 0, "R7 short tap", pulses, 0);
    chk(key_vec == held, "R7 vec unchanged", key_vec, held);

    // R9 two rows in one column
    pulses = 0;
    pressed = (16'(1) << 1) | (16'(1) << 5);
    waitn(150);
    chk(pulses == 0, "R9 multi no strobe", pulses, 0);
    chk(key_vec == held, "R9 vec unchanged", key_vec, held);
    chk(col_code == 2'd1, "R9 parked", col_code, 1);
    pressed = '0;
    waitn(60);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule